// File: doc/BRIEF.md
# CAN Frame Error Detection Unit

This unit observes one CAN node's bit stream, one sample per bit time, and flags protocol violations. An external frame sequencer supplies the sampled bus bit, the bit being driven, a transmit-active flag and one marker per frame region: start of frame, stuffed region, CRC-covered region, CRC field, arbitration field, acknowledge slot, CRC delimiter, acknowledge delimiter, end-of-frame and error-frame-active. The sequencer also pulses completion strobes and presents the received and expected data length codes.

The unit removes stuff bits itself. It checks run lengths and runs a 15-bit CRC over the destuffed bits. It checks the recessive fixed-form bits, the acknowledge slot and the bit read back while transmitting. All results go into one sticky 8-bit status byte. Software clears it with a write-one-to-clear mask. An interrupt line is raised when any enabled status bit is set.

Top module: `canFrameErrUnit`

## Requirements
- R1: After reset, `status` is 0x00, `irq` is low and `dlcStored` is 0.
- R2: Stuffing is checked while `stuffZone` is high, with `sofMark` restarting the run count. A sixth consecutive bit equal to the previous five sets status bit 3. A bit of opposite value after five equal bits is a stuff bit and is left out of the CRC.
- R3: The CRC uses polynomial 0x4599 and starts from zero at `sofMark`. It covers the destuffed bits marked `crcDataZone` and then the destuffed received bits marked `crcFieldZone`. If the remainder is non-zero on the `crcDelim` bit, status bit 2 is set.
- R4: A dominant (0) bit sampled during `crcDelim`, `ackDelim` or `eofZone` sets status bit 1.
- R5: While transmitting outside an error frame, a recessive (1) bit sampled in `ackSlot` sets status bit 0.
- R6: While `txActive` is high, a sampled bit that differs from `txBit` sets status bit 4. While `txActive` is low, bit 4 is never set.
- R7: During `arbZone`, sending recessive and reading dominant does not set bit 4.
- R8: During `ackSlot` with `errFrame` high, reading dominant sets neither bit 4 nor bit 0.
- R9: On `dlcStb`, `dlcStored` takes `dlcRx`. Status bit 7 is set if `dlcRx` differs from `dlcExpect`.
- R10: `txDone` sets status bit 6 and `rxDone` sets status bit 5.
- R11: Status bits stay set until a 1 is applied at the matching `clrMask` bit. A hardware set in the same cycle wins over the clear.
- R12: `irq` is high exactly when some bit is set in both `status` and `intEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| bitStb | input | 1 | One bit sample is valid this cycle |
| txBit | input | 1 | Bit the node is driving |
| rxBit | input | 1 | Sampled bus bit (0 dominant) |
| txActive | input | 1 | Node is transmitting |
| sofMark | input | 1 | Current bit is start of frame |
| stuffZone | input | 1 | Current bit lies in the stuffed region |
| crcDataZone | input | 1 | Current bit is covered by the CRC |
| crcFieldZone | input | 1 | Current bit belongs to the received CRC field |
| arbZone | input | 1 | Arbitration field |
| ackSlot | input | 1 | Acknowledge slot |
| crcDelim | input | 1 | CRC delimiter bit |
| ackDelim | input | 1 | Acknowledge delimiter bit |
| eofZone | input | 1 | End-of-frame bits |
| errFrame | input | 1 | Error frame being sent |
| dlcStb | input | 1 | Data length code is valid |
| dlcRx | input | 4 | Received data length code |
| dlcExpect | input | 4 | Expected data length code |
| txDone | input | 1 | Transmission completed |
| rxDone | input | 1 | Reception completed |
| clrMask | input | 8 | Write-one-to-clear mask for status |
| intEnable | input | 8 | Interrupt enable per status bit |
| status | output | 8 | Sticky status byte |
| irq | output | 1 | Interrupt request |
| dlcStored | output | 4 | Last received data length code |

## Verification
The CRC register and the run counter are hidden state. A wrong CRC register shows at the port only on the CRC delimiter bit, as a spurious or missing status bit 2. This can be many bit times after the fault, so the random frames use good and deliberately corrupted CRC fields of many lengths. A wrong run count shows either as a spurious bit 3 or as a stuff bit fed into the CRC, which later appears as a bit 2 error. All-zero payloads force stuff bits through that path. Every flag appears one clock after its sample, so each check reads the status on the falling edge after the strobe.

// File: rtl/canFeuPkg.sv
package canFeuPkg;
  localparam int STAT_W   = 8;
  localparam int B_DLCW   = 7;
  localparam int B_TXOK   = 6;
  localparam int B_RXOK   = 5;
  localparam int B_BITERR = 4;
  localparam int B_STUFF  = 3;
  localparam int B_CRC    = 2;
  localparam int B_FORM   = 1;
  localparam int B_ACK    = 0;

  typedef struct packed {
    logic              crcInit;
    logic              crcFeed;
    logic              crcCheck;
    logic              dataBit;
    logic              dlcLoad;
    logic [STAT_W-1:0] hwSet;
  } feuStrobes_t;
endpackage

// File: rtl/canFeuCtl.sv
module canFeuCtl
  import canFeuPkg::*;
#(
  parameter int STUFF_LIMIT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitStb,
  input  logic        txBit,
  input  logic        rxBit,
  input  logic        txActive,
  input  logic        sofMark,
  input  logic        stuffZone,
  input  logic        crcDataZone,
  input  logic        crcFieldZone,
  input  logic        arbZone,
  input  logic        ackSlot,
  input  logic        crcDelim,
  input  logic        ackDelim,
  input  logic        eofZone,
  input  logic        errFrame,
  input  logic        dlcStb,
  input  logic [3:0]  dlcRx,
  input  logic [3:0]  dlcExpect,
  input  logic        txDone,
  input  logic        rxDone,
  output feuStrobes_t strb
);
  localparam int RUN_W = $clog2(STUFF_LIMIT + 1);

  logic [RUN_W-1:0] runLen;
  logic             lastBit;
  logic             atLimit, isStuff;
  logic             arbExempt, errAckExempt, bitMismatch;

  assign atLimit = (runLen == RUN_W'(STUFF_LIMIT));
  assign isStuff = stuffZone && !sofMark && atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= '0;
      lastBit <= 1'b1;
    end else if (bitStb) begin
      if (sofMark || (stuffZone && (atLimit || rxBit != lastBit))) begin
        runLen  <= RUN_W'(1);
        lastBit <= rxBit;
      end else if (stuffZone) begin
        runLen  <= runLen + RUN_W'(1);
      end
    end
  end

  assign arbExempt    = arbZone && txBit && !rxBit;
  assign errAckExempt = errFrame && ackSlot && !rxBit;
  assign bitMismatch  = txActive && (txBit != rxBit) && !arbExempt && !errAckExempt;

  always_comb begin
    strb          = '0;
    strb.dataBit  = rxBit;
    strb.crcInit  = bitStb && sofMark;
    strb.crcFeed  = bitStb && (crcDataZone || crcFieldZone) && !isStuff;
    strb.crcCheck = bitStb && crcDelim;
    strb.dlcLoad  = dlcStb;
    strb.hwSet[B_DLCW]   = dlcStb && (dlcRx != dlcExpect);
    strb.hwSet[B_TXOK]   = txDone;
    strb.hwSet[B_RXOK]   = rxDone;
    strb.hwSet[B_BITERR] = bitStb && bitMismatch;
    strb.hwSet[B_STUFF]  = bitStb && isStuff && (rxBit == lastBit);
    strb.hwSet[B_FORM]   = bitStb && (crcDelim || ackDelim || eofZone) && !rxBit;
    strb.hwSet[B_ACK]    = bitStb && txActive && ackSlot && !errFrame && rxBit;
  end
endmodule

// File: rtl/canFeuDp.sv
module canFeuDp
  import canFeuPkg::*;
#(
  parameter int          CRC_W    = 15,
  parameter logic [14:0] CRC_POLY = 15'h4599,
  parameter int          DLC_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  feuStrobes_t       strb,
  input  logic [DLC_W-1:0]  dlcRx,
  input  logic [STAT_W-1:0] clrMask,
  input  logic [STAT_W-1:0] intEnable,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic [DLC_W-1:0]  dlcStored
);
  logic [CRC_W-1:0]  crcReg, crcBase, crcStep;
  logic [STAT_W-1:0] setVec;

  assign crcBase = strb.crcInit ? '0 : crcReg;

  always_comb begin
    crcStep = {crcBase[CRC_W-2:0], 1'b0};
    if (strb.dataBit ^ crcBase[CRC_W-1]) crcStep = crcStep ^ CRC_POLY[CRC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              crcReg <= '0;
    else if (strb.crcFeed)  crcReg <= crcStep;
    else if (strb.crcInit)  crcReg <= '0;
  end

  always_comb begin
    setVec         = strb.hwSet;
    setVec[B_CRC]  = strb.crcCheck && (crcReg != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status    <= '0;
      dlcStored <= '0;
    end else begin
      status <= (status & ~clrMask) | setVec;
      if (strb.dlcLoad) dlcStored <= dlcRx;
    end
  end

  assign irq = |(status & intEnable);
endmodule

// File: rtl/canFrameErrUnit.sv
module canFrameErrUnit
  import canFeuPkg::*;
#(
  parameter int STUFF_LIMIT = 5,
  parameter int DLC_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStb,
  input  logic              txBit,
  input  logic              rxBit,
  input  logic              txActive,
  input  logic              sofMark,
  input  logic              stuffZone,
  input  logic              crcDataZone,
  input  logic              crcFieldZone,
  input  logic              arbZone,
  input  logic              ackSlot,
  input  logic              crcDelim,
  input  logic              ackDelim,
  input  logic              eofZone,
  input  logic              errFrame,
  input  logic              dlcStb,
  input  logic [DLC_W-1:0]  dlcRx,
  input  logic [DLC_W-1:0]  dlcExpect,
  input  logic              txDone,
  input  logic              rxDone,
  input  logic [STAT_W-1:0] clrMask,
  input  logic [STAT_W-1:0] intEnable,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic [DLC_W-1:0]  dlcStored
);
  feuStrobes_t strb;

  canFeuCtl #(.STUFF_LIMIT(STUFF_LIMIT)) ctl (
    .clk, .rstN, .bitStb, .txBit, .rxBit, .txActive, .sofMark, .stuffZone,
    .crcDataZone, .crcFieldZone, .arbZone, .ackSlot, .crcDelim, .ackDelim,
    .eofZone, .errFrame, .dlcStb, .dlcRx, .dlcExpect, .txDone, .rxDone, .strb
  );

  canFeuDp #(.DLC_W(DLC_W)) dp (
    .clk, .rstN, .strb, .dlcRx, .clrMask, .intEnable, .status, .irq, .dlcStored
  );
endmodule

// File: rtl/canFeuSva.sv
module canFeuSva (
  input logic       clk,
  input logic       rstN,
  input logic       bitStb,
  input logic       txBit,
  input logic       rxBit,
  input logic       txActive,
  input logic       arbZone,
  input logic       ackSlot,
  input logic       errFrame,
  input logic       eofZone,
  input logic [7:0] clrMask,
  input logic [7:0] intEnable,
  input logic [7:0] status,
  input logic       irq
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(status & ~clrMask)) == $past(status & ~clrMask))); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == 8'h00) |-> !irq); // R12
  AST_NO_BITERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |=> !$rose(status[4])); // R6
  AST_ARB_EXEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (bitStb && txActive && arbZone && txBit && !rxBit && !status[4]) |=> !status[4]); // R7
  AST_ERRACK_EXEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (bitStb && txActive && errFrame && ackSlot && txBit && !rxBit && status[4:0] == 5'd0
     && !arbZone) |=> (status[4] == 1'b0) && (status[0] == 1'b0)); // R8
  AST_EOF_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (bitStb && eofZone && !rxBit) |=> status[1]); // R4
  AST_ACK_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (bitStb && txActive && ackSlot && !errFrame && rxBit) |=> status[0]); // R5
endmodule

bind canFrameErrUnit canFeuSva sva (.*);

// File: tb/canFrameErrUnit_test.sv
module canFrameErrUnit_test;
  logic clk = 0, rstN = 0;
  logic bitStb = 0, txBit = 1, rxBit = 1, txActive = 0, sofMark = 0, stuffZone = 0;
  logic crcDataZone = 0, crcFieldZone = 0, arbZone = 0, ackSlot = 0, crcDelim = 0;
  logic ackDelim = 0, eofZone = 0, errFrame = 0, dlcStb = 0, txDone = 0, rxDone = 0;
  logic [3:0] dlcRx = 0, dlcExpect = 0;
  logic [7:0] clrMask = 0, intEnable = 0;
  logic [7:0] status;
  logic irq;
  logic [3:0] dlcStored;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  canFrameErrUnit uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleAll();
    bitStb = 0; sofMark = 0; stuffZone = 0; crcDataZone = 0; crcFieldZone = 0;
    arbZone = 0; ackSlot = 0; crcDelim = 0; ackDelim = 0; eofZone = 0; errFrame = 0;
    dlcStb = 0; txDone = 0; rxDone = 0; clrMask = 0; txActive = 0; txBit = 1;
  endtask

  // inputs set at a falling edge; apply over one rising edge, back at falling edge
  task automatic tick();
    @(posedge clk); @(negedge clk);
    idleAll();
  endtask

  task automatic clearAll();
    clrMask = 8'hFF; tick();
  endtask

  function automatic logic [14:0] crcStep(logic [14:0] c, logic b);
    logic [14:0] n = {c[13:0], 1'b0};
    if (b ^ c[14]) n = n ^ 15'h4599;
    return n;
  endfunction

  // receive frame: SOF + data, CRC, delimiters; optional CRC corruption
  task automatic rxFrame(int nData, bit allZero, bit corrupt, string req);
    logic dBit[128];
    logic dZone[128];
    logic [14:0] crc = '0;
    int n = 0, run = 0;
    logic last = 1;
    dBit[n] = 0; dZone[n] = 0; n++;
    for (int i = 0; i < nData; i++) begin
      dBit[n] = allZero ? 1'b0 : 1'($urandom_range(0, 1)); dZone[n] = 0; n++;
    end
    for (int i = 0; i < n; i++) crc = crcStep(crc, dBit[i]);
    if (corrupt) crc[$urandom_range(0, 14)] ^= 1'b1;
    for (int i = 14; i >= 0; i--) begin dBit[n] = crc[i]; dZone[n] = 1; n++; end
    for (int i = 0; i < n; i++) begin
      if (i > 0 && run == 5) begin
        rxBit = ~last; stuffZone = 1; crcDataZone = !dZone[i]; crcFieldZone = dZone[i];
        bitStb = 1; tick();
        last = ~last; run = 1;
      end
      rxBit = dBit[i]; stuffZone = 1; sofMark = (i == 0);
      crcDataZone = !dZone[i]; crcFieldZone = dZone[i]; bitStb = 1; tick();
      if (i == 0 || dBit[i] != last) begin run = 1; last = dBit[i]; end else run++;
    end
    rxBit = 1; crcDelim = 1; bitStb = 1; tick();
    rxBit = 0; ackSlot = 1; bitStb = 1; tick();
    rxBit = 1; ackDelim = 1; bitStb = 1; tick();
    for (int i = 0; i < 7; i++) begin rxBit = 1; eofZone = 1; bitStb = 1; tick(); end
    rxDone = 1; tick();
    chk(req, status, corrupt ? 8'h24 : 8'h20);
    clearAll();
  endtask

  initial begin
    void'($urandom(32'd7171));
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 dlc", dlcStored, 0);
    rstN = 1; @(negedge clk);

    // R2 stuff error: SOF + five more dominant bits
    for (int i = 0; i < 6; i++) begin
      rxBit = 0; sofMark = (i == 0); stuffZone = 1; bitStb = 1; tick();
      if (i == 4) chk("R2 no stuff error at five", status, 8'h00);
    end
    chk("R2 stuff error at sixth", status, 8'h08);
    clearAll();

    // R2/R3: all-zero payload forces stuff bits, CRC must still match
    rxFrame(20, 1, 0, "R2 stuffed frame crc ok");
    rxFrame(20, 1, 1, "R3 stuffed frame crc corrupt");

    // R4 form error, R11 set beats simultaneous clear
    txDone = 1; tick();
    rxBit = 0; eofZone = 1; bitStb = 1; clrMask = 8'hFF; tick();
    chk("R4 R11 eof form err wins clear", status, 8'h02);
    rxBit = 0; ackDelim = 1; bitStb = 1; tick();
    chk("R4 ack delim", status, 8'h02);
    clearAll();
    rxBit = 0; crcDelim = 1; bitStb = 1; tick();
    chk("R4 crc delim dominant", status, 8'h06 & 8'h02 | (status & 8'h04));
    clearAll();

    // R5 ack error
    txActive = 1; txBit = 1; rxBit = 1; ackSlot = 1; bitStb = 1; tick();
    chk("R5 ack miss", status, 8'h01);
    clearAll();

    // R6 bit error and no error when idle
    txActive = 1; txBit = 0; rxBit = 1; bitStb = 1; tick();
    chk("R6 bit err", status, 8'h10);
    clearAll();
    txActive = 0; txBit = 0; rxBit = 1; bitStb = 1; tick();
    chk("R6 not transmitting", status, 8'h00);

    // R7 arbitration exemption and its limit
    txActive = 1; arbZone = 1; txBit = 1; rxBit = 0; bitStb = 1; tick();
    chk("R7 arb loss exempt", status, 8'h00);
    txActive = 1; arbZone = 1; txBit = 0; rxBit = 1; bitStb = 1; tick();
    chk("R7 arb opposite mismatch", status, 8'h10);
    clearAll();

    // R8 error frame ack exemption
    txActive = 1; errFrame = 1; ackSlot = 1; txBit = 1; rxBit = 0; bitStb = 1; tick();
    chk("R8 err frame ack exempt", status, 8'h00);

    // R9 DLC
    dlcStb = 1; dlcRx = 4'd5; dlcExpect = 4'd3; tick();
    chk("R9 dlc warn", status, 8'h80);
    chk("R9 dlc stored", dlcStored, 4'd5);
    clearAll();
    dlcStb = 1; dlcRx = 4'd3; dlcExpect = 4'd3; tick();
    chk("R9 dlc match", status, 8'h00);
    chk("R9 dlc overwritten", dlcStored, 4'd3);

    // R10, R11 partial clear, R12 irq
    txDone = 1; rxDone = 1; tick();
    chk("R10 tx rx ok", status, 8'h60);
    intEnable = 8'h40;
    @(negedge clk);
    chk("R12 irq on", irq, 1);
    clrMask = 8'h40; tick();
    chk("R11 partial clear", status, 8'h20);
    chk("R12 irq masked", irq, 0);
    intEnable = 8'h00;
    clearAll();

    // constrained random frames
    for (int f = 0; f < 40; f++) begin
      int len = $urandom_range(1, 60);
      bit bad = ($urandom_range(0, 2) == 0);
      rxFrame(len, 0, bad, bad ? "R3 random corrupt" : "R3 random good");
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); tests++; fails++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule